// File: doc/BRIEF.md
# Dual-Scan Nibble Video Capture

This block receives video from a flat panel controller over an 8-bit parallel bus. On every pixel clock one nibble arrives for the upper half of a 640x400 monochrome dual-scan panel and one for the lower half. The block rebuilds both half-panel rows, 640 bits each, and hands them to a frame store through one write port. That port carries a row index, both rows of data and a single-cycle write strobe. Row index r addresses panel row r in the upper half and panel row r+200 in the lower half.

The horizontal sync signal is active low and marks the span of a line. A capture mode input decides which nibbles of an over-long line are kept. Buffered mode keeps the ones nearest the start of the line. Pass-through mode keeps the ones nearest its end. Short and over-long lines raise flags. Vertical sync, sampled at the start of a line, returns the row index to the top of the frame.

Top module: `nvc_capture`

## Requirements
- R1: On each falling edge of `pclk` where `hsync` is low, both `upper_nib` and `lower_nib` are taken as the next nibble of the current line. When the line ends, `wr_upper` and `wr_lower` carry the two assembled rows under one strobe.
- R2: Nibble slot k (k = 0 leftmost) occupies data bits [639-4k : 636-4k], and nibble bit 3 is the leftmost pixel of its slot. Data bit 639 is therefore column 0 and data bit 0 is column 639.
- R3: With `pass_mode` = 0 (buffered), slots 0..159 take the first 160 nibbles of the line in order. Later nibbles of the same line have no effect on the data.
- R4: With `pass_mode` = 1 (pass-through), slots 0..159 hold the last 160 nibbles before `hsync` rises, with the newest in slot 159.
- R5: A line of fewer than 160 nibbles asserts `line_short` with the line-end pulse. The missing slots read zero: on the right in buffered mode, on the left in pass-through mode.
- R6: A line of more than 255 nibble clocks asserts `line_long` with the line-end pulse. A line of exactly 255 does not assert it.
- R7: When `vsync` is high on the first low sample of `hsync`, that line is written at row index 0.
- R8: Each line end moves the row index up by one. Line ends past index 199 give no strobe until the next frame start.
- R9: `wr_strobe` is high for exactly the one cycle following the falling edge at which `hsync` is first sampled high after a line. Data, row and flags are valid while it is high.
- R10: Synchronous active-high `rst` clears the nibble and row counters and drops the strobe and flags. The first line after reset without a frame start goes to row index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Pixel clock; all state changes on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| hsync | input | 1 | Line sync; low while a line's nibbles arrive |
| vsync | input | 1 | Frame sync; high at line start marks the first row |
| pass_mode | input | 1 | 0 = buffered (keep first nibbles), 1 = pass-through (keep last nibbles) |
| upper_nib | input | 4 | Pixel nibble for the upper half, bit 3 leftmost |
| lower_nib | input | 4 | Pixel nibble for the lower half, bit 3 leftmost |
| wr_strobe | output | 1 | One-cycle write request for both half rows |
| wr_row | output | 8 | Row index 0..199 within each half |
| wr_upper | output | 640 | Upper-half row data, bit 639 = column 0 |
| wr_lower | output | 640 | Lower-half row data, bit 639 = column 0 |
| line_short | output | 1 | Line had fewer than 160 nibbles |
| line_long | output | 1 | Line ran more than 255 nibble clocks |

## Verification
A wrong nibble counter shows up on the very next strobe in one of three ways: nibbles in the wrong slots, a wrong zero pad, or a wrong short or long flag. A broken row counter shows up as a wrong `wr_row` on the first line after a frame start or a reset. It also shows up as a strobe that does or does not appear after the 200th line. A bad sync edge detector shifts or removes the strobe by a cycle, so the check one cycle after the line end catches it at once.

// File: rtl/nvc_pkg.sv
package nvc_pkg;
   typedef enum logic {
      CAP_BUFFERED = 1'b0,
      CAP_PASSTHRU = 1'b1
   } cap_mode_e;
endpackage

// File: rtl/nvc_line_timer.sv
module nvc_line_timer #(
   parameter int SLOTS     = 160,
   parameter int MAX_CLKS  = 255,
   parameter int HALF_ROWS = 200,
   parameter int CNT_W     = 9,
   parameter int ROW_W     = 8
) (
   input  logic             pclk,
   input  logic             rst,
   input  logic             hsync,
   input  logic             vsync,
   output logic             cap,
   output logic             first,
   output logic [CNT_W-1:0] idx,
   output logic             wr_strobe,
   output logic [ROW_W-1:0] wr_row,
   output logic             line_short,
   output logic             line_long
);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_CLKS + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_CLKS);
   localparam logic [CNT_W-1:0] CNT_SLT = CNT_W'(SLOTS);
   localparam logic [ROW_W-1:0] ROW_END = ROW_W'(HALF_ROWS);

   logic             hs_q;
   logic [CNT_W-1:0] cnt_q;
   logic [ROW_W-1:0] row_q;
   logic             line_end;

   assign cap      = !hsync;
   assign first    = hs_q && !hsync;
   assign idx      = first ? '0 : cnt_q;
   assign line_end = hsync && !hs_q;

   always_ff @(negedge pclk) begin
      if (rst) begin
         hs_q       <= 1'b1;
         cnt_q      <= '0;
         row_q      <= '0;
         wr_strobe  <= 1'b0;
         wr_row     <= '0;
         line_short <= 1'b0;
         line_long  <= 1'b0;
      end else begin
         hs_q <= hsync;
         if (cap)
            cnt_q <= (idx == CNT_SAT) ? idx : idx + 1'b1;
         if (first && vsync)
            row_q <= '0;
         if (line_end) begin
            wr_strobe  <= (row_q < ROW_END);
            wr_row     <= row_q;
            line_short <= (cnt_q < CNT_SLT);
            line_long  <= (cnt_q > CNT_MAX);
            if (row_q < ROW_END)
               row_q <= row_q + 1'b1;
         end else begin
            wr_strobe  <= 1'b0;
            line_short <= 1'b0;
            line_long  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/nvc_row_assembler.sv
module nvc_row_assembler
   import nvc_pkg::*;
#(
   parameter int COLS  = 640,
   parameter int NIB_W = 4,
   parameter int CNT_W = 9
) (
   input  logic             pclk,
   input  logic             rst,
   input  logic             cap,
   input  logic             first,
   input  logic [CNT_W-1:0] idx,
   input  cap_mode_e        mode,
   input  logic [NIB_W-1:0] nib,
   output logic [COLS-1:0]  row_o
);
   localparam int SLOTS = COLS / NIB_W;

   logic [COLS-1:0] row_q;
   logic [COLS-1:0] base;
   logic [COLS-1:0] nxt;

   always_comb begin
      base = first ? '0 : row_q;
      nxt  = row_q;
      if (cap) begin
         if (mode == CAP_PASSTHRU) begin
            nxt = {base[COLS-NIB_W-1:0], nib};
         end else begin
            nxt = base;
            for (int k = 0; k < SLOTS; k++)
               if (idx == CNT_W'(k))
                  nxt[COLS-1-k*NIB_W -: NIB_W] = nib;
         end
      end
   end

   always_ff @(negedge pclk) begin
      if (rst) row_q <= '0;
      else     row_q <= nxt;
   end

   assign row_o = row_q;
endmodule

// File: rtl/nvc_capture.sv
module nvc_capture
   import nvc_pkg::*;
#(
   parameter int COLS      = 640,
   parameter int NIB_W     = 4,
   parameter int HALF_ROWS = 200,
   parameter int MAX_CLKS  = 255
) (
   input  logic              pclk,
   input  logic              rst,
   input  logic              hsync,
   input  logic              vsync,
   input  logic              pass_mode,
   input  logic [NIB_W-1:0]  upper_nib,
   input  logic [NIB_W-1:0]  lower_nib,
   output logic              wr_strobe,
   output logic [7:0]        wr_row,
   output logic [COLS-1:0]   wr_upper,
   output logic [COLS-1:0]   wr_lower,
   output logic              line_short,
   output logic              line_long
);
   localparam int SLOTS = COLS / NIB_W;
   localparam int CNT_W = $clog2(MAX_CLKS + 2);
   localparam int ROW_W = $clog2(HALF_ROWS + 1);

   initial begin : p_param_chk
      if (COLS % NIB_W != 0)  $error("COLS must be a multiple of NIB_W");
      if (SLOTS > MAX_CLKS)   $error("a full row must fit within MAX_CLKS");
      if (ROW_W > 8)          $error("HALF_ROWS exceeds the row port width");
   end

   logic             cap;
   logic             first;
   logic [CNT_W-1:0] idx;
   logic [ROW_W-1:0] row_idx;
   cap_mode_e        mode;
   logic [NIB_W-1:0] nib_in [2];
   logic [COLS-1:0]  rows   [2];

   assign mode      = cap_mode_e'(pass_mode);
   assign nib_in[0] = upper_nib;
   assign nib_in[1] = lower_nib;
   assign wr_upper  = rows[0];
   assign wr_lower  = rows[1];
   assign wr_row    = 8'(row_idx);

   nvc_line_timer #(
      .SLOTS(SLOTS), .MAX_CLKS(MAX_CLKS), .HALF_ROWS(HALF_ROWS),
      .CNT_W(CNT_W), .ROW_W(ROW_W)
   ) u_timer (
      .pclk(pclk), .rst(rst), .hsync(hsync), .vsync(vsync),
      .cap(cap), .first(first), .idx(idx),
      .wr_strobe(wr_strobe), .wr_row(row_idx),
      .line_short(line_short), .line_long(line_long)
   );

   for (genvar h = 0; h < 2; h++) begin : g_half
      nvc_row_assembler #(
         .COLS(COLS), .NIB_W(NIB_W), .CNT_W(CNT_W)
      ) u_asm (
         .pclk(pclk), .rst(rst), .cap(cap), .first(first), .idx(idx),
         .mode(mode), .nib(nib_in[h]), .row_o(rows[h])
      );
   end
endmodule

// File: rtl/nvc_capture_chk.sv
module nvc_capture_chk #(
   parameter int HALF_ROWS = 200
) (
   input logic       pclk,
   input logic       rst,
   input logic       hsync,
   input logic       wr_strobe,
   input logic [7:0] wr_row,
   input logic       line_short,
   input logic       line_long
);
   // R8: a strobe only ever addresses a row inside the half panel
   a_r8_row_in_range: assert property (@(negedge pclk) disable iff (rst)
      wr_strobe |-> (wr_row < 8'(HALF_ROWS)));

   // R9: strobe lasts one cycle
   a_r9_single_pulse: assert property (@(negedge pclk) disable iff (rst)
      wr_strobe |=> !wr_strobe);

   // R9: strobe follows an edge where hsync was sampled high
   a_r9_after_hs_high: assert property (@(negedge pclk) disable iff (rst)
      wr_strobe |-> $past(hsync));

   // R5/R6: a line cannot be both short and long
   a_r6_flags_exclusive: assert property (@(negedge pclk) disable iff (rst)
      line_short |-> !line_long);

   // R10: flags only rise after hsync has gone high
   a_r10_flag_after_hs: assert property (@(negedge pclk) disable iff (rst)
      (line_short || line_long) |-> $past(hsync));
endmodule

bind nvc_capture nvc_capture_chk #(.HALF_ROWS(HALF_ROWS)) u_chk (
   .pclk(pclk), .rst(rst), .hsync(hsync), .wr_strobe(wr_strobe),
   .wr_row(wr_row), .line_short(line_short), .line_long(line_long)
);

// File: tb/nvc_capture_tb.sv
module nvc_capture_tb;
   localparam int CLK_PERIOD = 10;
   localparam int COLS  = 640;
   localparam int SLOTS = 160;

   logic            pclk = 1'b0;
   logic            rst = 1'b1;
   logic            hsync = 1'b1;
   logic            vsync = 1'b0;
   logic            pass_mode = 1'b0;
   logic [3:0]      upper_nib = '0;
   logic [3:0]      lower_nib = '0;
   logic            wr_strobe;
   logic [7:0]      wr_row;
   logic [COLS-1:0] wr_upper;
   logic [COLS-1:0] wr_lower;
   logic            line_short;
   logic            line_long;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   nvc_capture u_dut (
      .pclk(pclk), .rst(rst), .hsync(hsync), .vsync(vsync),
      .pass_mode(pass_mode), .upper_nib(upper_nib), .lower_nib(lower_nib),
      .wr_strobe(wr_strobe), .wr_row(wr_row), .wr_upper(wr_upper),
      .wr_lower(wr_lower), .line_short(line_short), .line_long(line_long)
   );

   always #(CLK_PERIOD/2) pclk = ~pclk;

   task automatic chk(input bit ok, input string tag, input logic [COLS-1:0] act,
                      input logic [COLS-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] nib_of(int pat, int half, int i);
      if (pat == 1) begin
         if (half == 0) return (i == 0) ? 4'h8 : (i == SLOTS-1) ? 4'h1 : 4'h0;
         return (i == 0) ? 4'h1 : 4'h0;
      end
      if (half == 0) return 4'((i*7 + 1 + pat) & 15);
      return 4'((i*3 + 5 + pat) & 15);
   endfunction

   // expected row from R2..R5
   function automatic logic [COLS-1:0] exp_row(int n, int pat, int half, bit pt);
      logic [COLS-1:0] r = '0;
      int m = (n < SLOTS) ? n : SLOTS;
      for (int k = 0; k < SLOTS; k++) begin
         if (!pt && k < m)
            r[COLS-1-4*k -: 4] = nib_of(pat, half, k);
         if (pt && k >= SLOTS-m)
            r[COLS-1-4*k -: 4] = nib_of(pat, half, n - SLOTS + k);
      end
      return r;
   endfunction

   // drive one line, then check the write port
   task automatic send_line(input int n, input bit vs, input int pat, input bit pt,
                            input int exp_rw, input bit exp_wr, input string tag);
      pass_mode = pt;
      for (int i = 0; i < n; i++) begin
         @(posedge pclk);
         hsync = 1'b0;
         vsync = (i == 0) ? vs : 1'b0;
         upper_nib = nib_of(pat, 0, i);
         lower_nib = nib_of(pat, 1, i);
      end
      @(posedge pclk);
      hsync = 1'b1; vsync = 1'b0; upper_nib = '0; lower_nib = '0;
      @(posedge pclk);
      chk(wr_strobe == exp_wr, {tag, " R9 strobe"}, COLS'(wr_strobe), COLS'(exp_wr));
      if (exp_wr) begin
         chk(wr_row == 8'(exp_rw), {tag, " R8 row"}, COLS'(wr_row), COLS'(exp_rw));
         chk(wr_upper == exp_row(n, pat, 0, pt), {tag, " R1 upper"}, wr_upper,
             exp_row(n, pat, 0, pt));
         chk(wr_lower == exp_row(n, pat, 1, pt), {tag, " R1 lower"}, wr_lower,
             exp_row(n, pat, 1, pt));
      end
      chk(line_short == (n < SLOTS), {tag, " R5 short"}, COLS'(line_short),
          COLS'(n < SLOTS));
      chk(line_long == (n > 255), {tag, " R6 long"}, COLS'(line_long), COLS'(n > 255));
      @(posedge pclk);
      chk(wr_strobe == 1'b0, {tag, " R9 one cycle"}, COLS'(wr_strobe), '0);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(posedge pclk);
      chk(!wr_strobe && !line_short && !line_long, "R10 reset outputs",
          COLS'({wr_strobe, line_short, line_long}), '0);
      rst = 1'b0;
   endtask

   task automatic t_buffered();
      send_line(160, 1'b1, 0, 1'b0, 0, 1'b1, "R3 R7 buffered full");
      send_line(160, 1'b0, 1, 1'b0, 1, 1'b1, "R2 bit order");
      chk(wr_upper[639] && wr_upper[0] && wr_lower[636], "R2 corner bits",
          wr_upper, exp_row(160, 1, 0, 1'b0));
      send_line(200, 1'b0, 2, 1'b0, 2, 1'b1, "R3 excess ignored");
   endtask

   task automatic t_passthru();
      send_line(200, 1'b0, 3, 1'b1, 3, 1'b1, "R4 last nibbles");
      send_line(160, 1'b0, 4, 1'b1, 4, 1'b1, "R4 exact");
   endtask

   task automatic t_short();
      send_line(100, 1'b0, 5, 1'b0, 5, 1'b1, "R5 buffered pad right");
      send_line(37, 1'b0, 6, 1'b1, 6, 1'b1, "R5 passthru pad left");
   endtask

   task automatic t_long();
      send_line(255, 1'b0, 7, 1'b0, 7, 1'b1, "R6 exactly 255");
      send_line(256, 1'b0, 8, 1'b0, 8, 1'b1, "R6 over 255");
      send_line(300, 1'b0, 9, 1'b1, 9, 1'b1, "R6 R4 over in passthru");
   endtask

   task automatic t_rows();
      send_line(1, 1'b1, 0, 1'b0, 0, 1'b1, "R7 frame start");
      for (int r = 1; r < 200; r++)
         send_line(1, 1'b0, r & 7, 1'b0, r, 1'b1, "R8 row step");
      send_line(1, 1'b0, 0, 1'b0, 0, 1'b0, "R8 past last row");
      send_line(3, 1'b1, 2, 1'b1, 0, 1'b1, "R7 new frame");
   endtask

   task automatic t_reset_mid();
      send_line(5, 1'b0, 1, 1'b0, 1, 1'b1, "R10 before reset");
      t_reset();
      send_line(20, 1'b0, 3, 1'b0, 0, 1'b1, "R10 row restarts");
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_buffered();
      t_passthru();
      t_short();
      t_long();
      t_rows();
      t_reset_mid();
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge pclk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end
endmodule